// File: doc/BRIEF.md
# Shared-Bus Converter Scan Sequencer

This block runs a bank of eight analog-to-digital converters whose 10-bit outputs all sit on one shared three-state bus. Each converter has its own active-low select line. Holding a line high keeps that converter idle with its outputs floating. Pulling it low starts a conversion, and the converter drives the bus by itself once it finishes. The block never lets more than one converter drive the bus. When it moves to a new converter, the release of the old one and the selection of the new one happen on the same clock edge.

Completion is not reported per converter. The ready outputs are wire-ORed in two groups of four, and each group gives one active-low status line. The block synchronises these lines and watches the one that belongs to the selected channel. Because a group line can still be low from a converter that was just released, the block first waits to see that line high, then waits for it to go low, then lets the bus settle for a set number of cycles before it samples. It builds each result from an 8-bit low port and a 2-bit high port and tags it with the channel number.

Channels are converted either by a free-running ascending scan or one at a time on a valid/ready request. A converter that does not finish produces a tagged timeout result. A channel that is requested again while it is still selected is first released for a minimum blanking time.

Top module: `mux_scan_ctrl`

## Requirements
- R1: While reset is asserted, all eight select lines are high, `res_valid` is low and the scan pointer returns to channel 0.
- R2: At no time is more than one select line low.
- R3: A request for channel c pulls line c low. Its result carries tag c, and `res_data` is {`port_hi`, `port_lo`}, with `port_hi` in bits 9:8.
- R4: With `auto_en` high, conversions go through channels 0,1,…,7 in ascending order and wrap back to 0.
- R5: In scan mode, the clock edge after a good result selects the next channel. The line just read goes high on that same edge.
- R6: The group status line of channel c is bit c/4 (channels 0–3 use bit 0). After a selection, the block ignores that line until it has seen it high at least once.
- R7: The bus is sampled SETTLE_CYC cycles after the synchronised status line is first seen low, so a bus that settles late is still captured correctly.
- R8: If no completion is seen within TIMEOUT_CYC cycles of a selection, one result is produced with `res_timeout`=1, data 0 and the channel tag. All lines are high in that result cycle.
- R9: Selecting the channel that was selected last always comes after at least BLANK_CYC cycles with every line high.
- R10: `req_ready` is high only when the block is idle and scan mode is off. A request made while `req_ready` is low is dropped and produces no result.
- R11: Only the selected channel's group line counts. A low level on the other group's line does not complete a conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Free-running ascending scan when high |
| req_valid | input | 1 | Single-conversion request |
| req_chan | input | 3 | Channel to convert on request |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| conv_n | output | 8 | Active-low select/start line per converter |
| rdy_grp_n | input | 2 | Wire-ORed active-low ready, one per group of four |
| port_lo | input | 8 | Shared bus, result bits 7:0 |
| port_hi | input | 2 | Shared bus, result bits 9:8 |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 10 | Captured result (0 on timeout) |
| res_chan | output | 3 | Channel tag of the result |
| res_timeout | output | 1 | Result ended by timeout |

## Verification
The bench uses a model converter. Its ready line stays low for a while after the converter is released, and its bus word is still garbage for a few cycles after ready. Scan runs that step between two channels of the same group would read the stale ready and capture the garbage word if either the high-before-low guard or the settle delay were missing. Requests for a different channel, the same channel, and a channel made while the block is busy separate direct handover, forced blanking and dropped requests. A dead converter, with the other group's line held low at the same time, separates the timeout path from a wrong group lookup.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_BLANK  = 3'd1,
    ST_ARM    = 3'd2,
    ST_WAIT   = 3'd3,
    ST_SETTLE = 3'd4
  } scan_state_e;
endpackage

// File: rtl/scan_sync.sv
module scan_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_async[b]};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
      end
      assign q_sync[b] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/scan_sel_decode.sv
module scan_sel_decode #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic [CH_W-1:0]   chan,
  input  logic              sel_on,
  output logic [NUM_CH-1:0] conv_n
);
  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : g_line
      assign conv_n[i] = !(sel_on && (chan == CH_W'(i)));
    end
  endgenerate
endmodule

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int CH_W        = 3,
  parameter int RES_W       = 10,
  parameter int GRP_SIZE    = 4,
  parameter int NUM_GRP     = 2,
  parameter int TIMEOUT_CYC = 8192,
  parameter int BLANK_CYC   = 256,
  parameter int SETTLE_CYC  = 64,
  parameter int CNT_W       = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               auto_en,
  input  logic               req_valid,
  input  logic [CH_W-1:0]    req_chan,
  output logic               req_ready,
  input  logic [NUM_GRP-1:0] grp_s,
  input  logic [RES_W-1:0]   bus_word,
  input  logic [CNT_W-1:0]   cnt,
  output logic               cnt_clr,
  output logic               cnt_en,
  output logic [CH_W-1:0]    sel_chan,
  output logic               sel_on,
  output logic               res_valid,
  output logic [RES_W-1:0]   res_data,
  output logic [CH_W-1:0]    res_chan,
  output logic               res_timeout
);
  localparam int GRP_SH = $clog2(GRP_SIZE);
  localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam logic [CNT_W-1:0] TMO_LAST    = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] BLANK_LAST  = CNT_W'(BLANK_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

  scan_state_e      state_q, state_d;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic             sel_q, sel_d;
  logic             have_q, have_d;
  logic [CH_W-1:0]  ptr_q, ptr_d;
  logic             rv_q, rv_d;
  logic [RES_W-1:0] rd_q, rd_d;
  logic [CH_W-1:0]  rc_q, rc_d;
  logic             rt_q, rt_d;

  logic             go;
  logic [CH_W-1:0]  go_ch;
  logic [CH_W-1:0]  gidx_full;
  logic [GRP_W-1:0] gidx;
  logic             grp_line;
  logic             tmo_hit;

  assign gidx_full = chan_q >> GRP_SH;
  assign gidx      = gidx_full[GRP_W-1:0];
  assign grp_line  = grp_s[gidx];
  assign tmo_hit   = (cnt == TMO_LAST);

  // start selection: scan pointer in scan mode, else a handshake request
  always_comb begin
    go    = 1'b0;
    go_ch = ptr_q;
    ptr_d = ptr_q;
    if (state_q == ST_IDLE) begin
      if (auto_en) begin
        go    = 1'b1;
        go_ch = ptr_q;
        ptr_d = (ptr_q == CH_W'(NUM_CH - 1)) ? '0 : ptr_q + 1'b1;
      end else if (req_valid) begin
        go    = 1'b1;
        go_ch = req_chan;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    chan_d  = chan_q;
    sel_d   = sel_q;
    have_d  = have_q;
    rv_d    = 1'b0;
    rd_d    = rd_q;
    rc_d    = rc_q;
    rt_d    = rt_q;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          chan_d  = go_ch;
          have_d  = 1'b1;
          cnt_clr = 1'b1;
          if (have_q && (go_ch == chan_q)) begin
            sel_d   = 1'b0;
            state_d = ST_BLANK;
          end else begin
            sel_d   = 1'b1;
            state_d = ST_ARM;
          end
        end
      end
      ST_BLANK: begin
        cnt_en = 1'b1;
        if (cnt == BLANK_LAST) begin
          sel_d   = 1'b1;
          cnt_clr = 1'b1;
          state_d = ST_ARM;
        end
      end
      ST_ARM, ST_WAIT: begin
        cnt_en = 1'b1;
        if (tmo_hit) begin
          rv_d    = 1'b1;
          rd_d    = '0;
          rc_d    = chan_q;
          rt_d    = 1'b1;
          sel_d   = 1'b0;
          state_d = ST_IDLE;
        end else if ((state_q == ST_ARM) && grp_line) begin
          state_d = ST_WAIT;
        end else if ((state_q == ST_WAIT) && !grp_line) begin
          cnt_clr = 1'b1;
          state_d = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        cnt_en = 1'b1;
        if (cnt == SETTLE_LAST) begin
          rv_d    = 1'b1;
          rd_d    = bus_word;
          rc_d    = chan_q;
          rt_d    = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      sel_q   <= 1'b0;
      have_q  <= 1'b0;
      ptr_q   <= '0;
      rv_q    <= 1'b0;
      rd_q    <= '0;
      rc_q    <= '0;
      rt_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      sel_q   <= sel_d;
      have_q  <= have_d;
      ptr_q   <= ptr_d;
      rv_q    <= rv_d;
      rd_q    <= rd_d;
      rc_q    <= rc_d;
      rt_q    <= rt_d;
    end
  end

  assign req_ready   = (state_q == ST_IDLE) && !auto_en;
  assign sel_chan    = chan_q;
  assign sel_on      = sel_q;
  assign res_valid   = rv_q;
  assign res_data    = rd_q;
  assign res_chan    = rc_q;
  assign res_timeout = rt_q;
endmodule

// File: rtl/mux_scan_ctrl.sv
module mux_scan_ctrl #(
  parameter int NUM_CH      = 8,
  parameter int GRP_SIZE    = 4,
  parameter int LO_W        = 8,
  parameter int HI_W        = 2,
  parameter int TIMEOUT_CYC = 8192,
  parameter int BLANK_CYC   = 256,
  parameter int SETTLE_CYC  = 64,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = $clog2(NUM_CH),
  localparam int NUM_GRP    = NUM_CH / GRP_SIZE,
  localparam int RES_W      = LO_W + HI_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               auto_en,
  input  logic               req_valid,
  input  logic [CH_W-1:0]    req_chan,
  output logic               req_ready,
  output logic [NUM_CH-1:0]  conv_n,
  input  logic [NUM_GRP-1:0] rdy_grp_n,
  input  logic [LO_W-1:0]    port_lo,
  input  logic [HI_W-1:0]    port_hi,
  output logic               res_valid,
  output logic [RES_W-1:0]   res_data,
  output logic [CH_W-1:0]    res_chan,
  output logic               res_timeout
);
  localparam int MAX_AB = (TIMEOUT_CYC > BLANK_CYC) ? TIMEOUT_CYC : BLANK_CYC;
  localparam int MAX_C  = (MAX_AB > SETTLE_CYC) ? MAX_AB : SETTLE_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  logic [NUM_GRP-1:0] grp_s;
  logic [CNT_W-1:0]   cnt;
  logic               cnt_clr;
  logic               cnt_en;
  logic [CH_W-1:0]    sel_chan;
  logic               sel_on;
  logic [RES_W-1:0]   bus_word;

  assign bus_word = {port_hi, port_lo};

  scan_sync #(.W(NUM_GRP), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_async(rdy_grp_n), .q_sync(grp_s)
  );

  scan_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en), .cnt(cnt)
  );

  scan_fsm #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .RES_W(RES_W), .GRP_SIZE(GRP_SIZE),
    .NUM_GRP(NUM_GRP), .TIMEOUT_CYC(TIMEOUT_CYC), .BLANK_CYC(BLANK_CYC),
    .SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .req_valid(req_valid),
    .req_chan(req_chan), .req_ready(req_ready), .grp_s(grp_s),
    .bus_word(bus_word), .cnt(cnt), .cnt_clr(cnt_clr), .cnt_en(cnt_en),
    .sel_chan(sel_chan), .sel_on(sel_on), .res_valid(res_valid),
    .res_data(res_data), .res_chan(res_chan), .res_timeout(res_timeout)
  );

  scan_sel_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) dec_i (
    .chan(sel_chan), .sel_on(sel_on), .conv_n(conv_n)
  );
endmodule

// File: rtl/scan_ctrl_chk.sv
module scan_ctrl_chk #(
  parameter int NUM_CH    = 8,
  parameter int CH_W      = 3,
  parameter int RES_W     = 10,
  parameter int BLANK_CYC = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              auto_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic [NUM_CH-1:0] conv_n,
  input logic              res_valid,
  input logic [RES_W-1:0]  res_data,
  input logic [CH_W-1:0]   res_chan,
  input logic              res_timeout
);
  localparam int HW = $clog2(BLANK_CYC + 1) + 1;

  logic              any_low;
  logic [CH_W-1:0]   low_ch;
  logic [CH_W-1:0]   last_ch;
  logic              last_v;
  logic [HW-1:0]     hi_cnt;
  logic [CH_W-1:0]   nxt_ch;
  logic [NUM_CH-1:0] nxt_conv_n;

  always_comb begin
    any_low = ~&conv_n;
    low_ch  = '0;
    for (int i = 0; i < NUM_CH; i++) if (!conv_n[i]) low_ch = CH_W'(i);
    nxt_ch     = (res_chan == CH_W'(NUM_CH - 1)) ? '0 : res_chan + 1'b1;
    nxt_conv_n = ~(NUM_CH'(1) << nxt_ch);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ch <= '0;
      last_v  <= 1'b0;
      hi_cnt  <= '0;
    end else if (any_low) begin
      last_ch <= low_ch;
      last_v  <= 1'b1;
      hi_cnt  <= '0;
    end else if (hi_cnt < HW'(BLANK_CYC)) begin
      hi_cnt  <= hi_cnt + 1'b1;
    end
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_idle_chk: assert (conv_n == '1 && !res_valid);
  end

  // R2
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~conv_n) <= 1);

  // R5
  scan_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_timeout && auto_en) |=> (conv_n == $past(nxt_conv_n)));

  // R8
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_timeout) |-> (conv_n == '1 && res_data == '0));

  // R9
  reselect_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_low && last_v && low_ch == last_ch && hi_cnt != '0) |-> (hi_cnt >= HW'(BLANK_CYC)));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind mux_scan_ctrl scan_ctrl_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .RES_W(RES_W), .BLANK_CYC(BLANK_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .req_valid(req_valid),
  .req_ready(req_ready), .conv_n(conv_n), .res_valid(res_valid),
  .res_data(res_data), .res_chan(res_chan), .res_timeout(res_timeout)
);

// File: tb/mux_scan_ctrl_tb_top.sv
module mux_scan_ctrl_tb_top;
  localparam int TMO    = 200;
  localparam int BLK    = 6;
  localparam int SET    = 3;
  localparam int CONV_T = 40;
  localparam int REL_T  = 20;
  localparam int DV_T   = 2;

  logic       clk;
  logic       rst_n;
  logic       auto_en;
  logic       req_valid;
  logic [2:0] req_chan;
  logic       req_ready;
  logic [7:0] conv_n;
  logic [1:0] rdy_grp_n;
  logic [7:0] port_lo;
  logic [1:0] port_hi;
  logic       res_valid;
  logic [9:0] res_data;
  logic [2:0] res_chan;
  logic       res_timeout;

  int n_cmp;
  int n_bad;

  mux_scan_ctrl #(.TIMEOUT_CYC(TMO), .BLANK_CYC(BLK), .SETTLE_CYC(SET)) dut_i (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .req_valid(req_valid),
    .req_chan(req_chan), .req_ready(req_ready), .conv_n(conv_n),
    .rdy_grp_n(rdy_grp_n), .port_lo(port_lo), .port_hi(port_hi),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
    .res_timeout(res_timeout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- converter bank model ----------------
  int       mcnt [8];
  int       mrel [8];
  int       mdv  [8];
  logic     mdone[8];
  logic     cprev[8];
  logic [7:0] dead;
  logic [1:0] force_low;
  logic [9:0] base;

  function automatic logic [9:0] val(int ch);
    return 10'((ch * 37 + 11) ^ base);
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) begin
      mcnt[i] = 0; mrel[i] = 0; mdv[i] = 0; mdone[i] = 1'b0; cprev[i] = 1'b1;
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < 8; i++) begin
      cprev[i] <= conv_n[i];
      if (!conv_n[i]) begin
        mrel[i] <= 0;
        if (cprev[i]) begin
          mdone[i] <= 1'b0; mcnt[i] <= 0; mdv[i] <= 0;
        end else if (!mdone[i]) begin
          if (mcnt[i] >= CONV_T - 1 && !dead[i]) mdone[i] <= 1'b1;
          mcnt[i] <= mcnt[i] + 1;
        end else if (mdv[i] < DV_T) begin
          mdv[i] <= mdv[i] + 1;
        end
      end else begin
        mcnt[i] <= 0; mdv[i] <= 0;
        if (mdone[i]) begin
          if (mrel[i] >= REL_T - 1) begin mdone[i] <= 1'b0; mrel[i] <= 0; end
          else mrel[i] <= mrel[i] + 1;
        end
      end
    end
  end

  always_comb begin
    logic [9:0] bus;
    logic [7:0] dr_n;
    bus = 10'h155;
    for (int i = 0; i < 8; i++) begin
      dr_n[i] = !mdone[i];
      if (!conv_n[i] && mdone[i]) bus = (mdv[i] >= DV_T) ? val(i) : 10'h2AA;
    end
    rdy_grp_n[0] = (&dr_n[3:0]) && !force_low[0];
    rdy_grp_n[1] = (&dr_n[7:4]) && !force_low[1];
    port_lo = bus[7:0];
    port_hi = bus[9:8];
  end

  // ---------------- result monitor ----------------
  logic [9:0] rec_data[64];
  logic [2:0] rec_chan[64];
  logic       rec_tmo [64];
  logic [7:0] rec_conv[64];
  logic [7:0] rec_next[64];
  int  n_rec;
  bit  pend;
  int  multi_low;

  initial begin n_rec = 0; pend = 1'b0; multi_low = 0; end

  always @(negedge clk) begin
    if (rst_n && $countones(~conv_n) > 1) multi_low++;
    if (pend) begin rec_next[n_rec-1] = conv_n; pend = 1'b0; end
    if (rst_n && res_valid && n_rec < 64) begin
      rec_data[n_rec] = res_data;
      rec_chan[n_rec] = res_chan;
      rec_tmo[n_rec]  = res_timeout;
      rec_conv[n_rec] = conv_n;
      n_rec++;
      pend = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    while (n_rec < n) @(negedge clk);
  endtask

  task automatic send_req(input logic [2:0] c);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_chan = c;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(conv_n == 8'hFF, "R1", "lines in reset", conv_n, 8'hFF);
    chk(res_valid == 1'b0, "R1", "valid in reset", res_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(conv_n == 8'hFF, "R1", "lines after reset", conv_n, 8'hFF);
    chk(req_ready == 1'b1, "R10", "ready when idle", req_ready, 1);
  endtask

  task automatic t_request(input logic [2:0] c);
    int k;
    k = n_rec;
    send_req(c);
    chk(conv_n == ~(8'h01 << c), "R3", "selected line", conv_n, ~(8'h01 << c));
    wait_n(k + 1);
    chk(rec_chan[k] == c, "R3", "channel tag", rec_chan[k], c);
    // R7: late-settling bus must still give the real word
    chk(rec_data[k] == val(c) && !rec_tmo[k], "R7", "captured word", rec_data[k], val(c));
    @(negedge clk);
    chk(conv_n == ~(8'h01 << c), "R3", "held after result", conv_n, ~(8'h01 << c));
  endtask

  task automatic t_same_chan(input logic [2:0] c);
    int k;
    int hi;
    k = n_rec;
    hi = 0;
    send_req(c);
    while (conv_n == 8'hFF && hi < 1000) begin hi++; @(negedge clk); end
    chk(hi == BLK, "R9", "blank cycles before reselect", hi, BLK);
    wait_n(k + 1);
    chk(rec_chan[k] == c && rec_data[k] == val(c), "R9", "word after reselect", rec_data[k], val(c));
  endtask

  task automatic t_busy_ignore();
    int k;
    k = n_rec;
    send_req(3'd5);
    repeat (10) @(negedge clk);
    chk(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
    req_valid = 1'b1; req_chan = 3'd3;
    @(negedge clk);
    req_valid = 1'b0;
    wait_n(k + 1);
    repeat (150) @(negedge clk);
    chk(n_rec == k + 1, "R10", "results after busy request", n_rec - k, 1);
    chk(rec_chan[k] == 3'd5 && rec_data[k] == val(5), "R6", "group-1 word", rec_data[k], val(5));
    chk(conv_n == ~8'h20, "R10", "line kept after dropped request", conv_n, ~8'h20);
  endtask

  task automatic t_timeout();
    int k;
    k = n_rec;
    dead[6] = 1'b1;
    force_low[0] = 1'b1;
    send_req(3'd6);
    wait_n(k + 1);
    chk(rec_tmo[k] == 1'b1, "R8", "timeout flag", rec_tmo[k], 1);
    chk(rec_chan[k] == 3'd6 && rec_data[k] == 10'd0, "R8", "timeout word", rec_data[k], 0);
    chk(rec_conv[k] == 8'hFF, "R8", "lines at timeout", rec_conv[k], 8'hFF);
    chk(rec_tmo[k] == 1'b1, "R11", "other group low ignored", rec_tmo[k], 1);
    force_low[0] = 1'b0;
    dead[6] = 1'b0;
    repeat (5) @(negedge clk);
    t_same_chan(3'd6);
  endtask

  task automatic t_auto();
    int k;
    k = n_rec;
    base = 10'h2C3;
    @(negedge clk);
    auto_en = 1'b1;
    wait_n(k + 10);
    auto_en = 1'b0;
    for (int j = 0; j < 10; j++) begin
      chk(rec_chan[k+j] == 3'(j % 8), "R4", "scan order", rec_chan[k+j], j % 8);
      // R6: stale ready from the released neighbour must not end the conversion
      chk(rec_data[k+j] == val(j % 8) && !rec_tmo[k+j], "R6", "scan word",
          rec_data[k+j], val(j % 8));
    end
    for (int j = 0; j < 9; j++)
      chk(rec_next[k+j] == ~(8'h01 << ((j + 1) % 8)), "R5", "handover",
          rec_next[k+j], ~(8'h01 << ((j + 1) % 8)));
    repeat (200) @(negedge clk);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; auto_en = 1'b0; req_valid = 1'b0; req_chan = 3'd0;
    dead = 8'h00; force_low = 2'b00; base = 10'h0A5;
    repeat (3) @(negedge clk);
    t_reset();
    t_request(3'd2);
    t_same_chan(3'd2);
    t_busy_ignore();
    t_timeout();
    t_request(3'd4);
    t_auto();
    chk(multi_low == 0, "R2", "cycles with two lines low", multi_low, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule